// File: doc/BRIEF.md
# Write-Strobe Capture and Qualification Front End

This block turns three asynchronous active-low bus strobes (chip select, write strobe, read enable) plus an address bus and a data bus into one clean, clocked write command for a downstream command register. All pins are oversampled through two-flop synchronizers. A write cycle exists only while chip select and write strobe are both low and read enable is high.

The address is taken at the moment the second of the two write strobes goes low. The data is taken at the moment the first of them returns high. The low overlap must last a parameterised number of clock cycles, otherwise it is treated as a glitch. Several inhibits can cancel a cycle: read enable dropping during the cycle, a supply-low flag, a missing high-voltage enable, and a write strobe that is already active when reset is released. A qualified cycle produces a single-cycle `cmd_valid` pulse with the captured address and data.

The command output is a valid-only stream with no ready input. Pin-driven write cycles cannot be stalled, so the consumer must accept every `cmd_valid` beat in the cycle it appears. `cmd_addr` and `cmd_data` hold their values until the next qualified cycle. `read_reset_req` is a plain level that asks the command register to fall back to read mode.

Top module: `strobe_write_capture`

## Requirements
- R1: A cycle starts only when chip select and write strobe are both low while read enable is high. Either strobe low alone, or both low while read enable is low, never produces `cmd_valid`.
- R2: `cmd_addr` equals the address bus value sampled in the same clock as the later of the two strobe falls. If both fall in one sample, that sample's address is used.
- R3: `cmd_data` equals the data bus value sampled in the same clock as the earlier of the two strobe rises.
- R4: A qualified cycle needs the synchronized overlap of both strobes low to last at least MIN_LOW clock cycles (default 3). A shorter overlap gives no `cmd_valid`.
- R5: If read enable is seen low in any clock of an active cycle, including its closing clock, the cycle is discarded.
- R6: While the synchronized supply-low flag is high, `read_reset_req` is high and no `cmd_valid` is issued. A supply-low seen during a cycle discards that cycle.
- R7: If the synchronized high-voltage enable is low in the closing clock of a cycle, no `cmd_valid` is issued.
- R8: If both strobes are already low when reset is released, no cycle is accepted until both strobes have been seen inactive.
- R9: A qualified cycle yields `cmd_valid` high for exactly one clock, within three clock edges after the releasing strobe edge is sampled. After reset, `cmd_valid` and `read_reset_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select pin, active low, asynchronous |
| wstb_n | input | 1 | Write strobe pin, active low, asynchronous |
| ren_n | input | 1 | Read enable pin, active low, asynchronous |
| addr_in | input | AW | Address bus pins |
| data_in | input | DW | Data bus pins |
| supply_low | input | 1 | Supply-below-threshold flag |
| hv_enable | input | 1 | High programming voltage present flag |
| cmd_valid | output | 1 | One-clock write command pulse |
| cmd_addr | output | AW | Captured write address |
| cmd_data | output | DW | Captured write data |
| read_reset_req | output | 1 | Request to return the command register to read mode |

## Verification
The address capture and the data capture can collapse onto the same edge class. When both strobes fall in the same sample, that one clock both opens the cycle and takes the address. When both rise together, one clock both closes the cycle and takes the data. The bench sweeps every ordering of falls and rises, with zero and non-zero gaps, across overlap lengths on both sides of MIN_LOW. It changes the address bus right after the later fall and the data bus right after the release, and compares the captured values against those computed for the exact sampling clock. A second collision, the release arriving in the same cycle as a supply-low or a read-enable drop, is judged by the absence of any pulse.

// File: rtl/wsc_pkg.sv
package wsc_pkg;
  localparam int SYNC_STAGES = 2;

  typedef enum logic {
    WC_IDLE   = 1'b0,
    WC_ACTIVE = 1'b1
  } wc_state_e;
endpackage

// File: rtl/wsc_sync.sv
module wsc_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/wsc_low_timer.sv
module wsc_low_timer #(
  parameter int MIN_LOW = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic met
);
  localparam int CW = (MIN_LOW < 2) ? 1 : $clog2(MIN_LOW + 1);
  localparam logic [CW-1:0] LIMIT = CW'(MIN_LOW);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (restart)               cnt_q <= CW'(1);
    else if (run && cnt_q < LIMIT)  cnt_q <= cnt_q + CW'(1);
  end

  assign met = (cnt_q >= LIMIT);
endmodule

// File: rtl/strobe_write_capture.sv
module strobe_write_capture
  import wsc_pkg::*;
#(
  parameter int AW      = 15,
  parameter int DW      = 8,
  parameter int MIN_LOW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          wstb_n,
  input  logic          ren_n,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] data_in,
  input  logic          supply_low,
  input  logic          hv_enable,
  output logic          cmd_valid,
  output logic [AW-1:0] cmd_addr,
  output logic [DW-1:0] cmd_data,
  output logic          read_reset_req
);
  localparam int CTL_W = 5;
  localparam int BUS_W = AW + DW;

  logic [CTL_W-1:0] ctl_s;
  logic [BUS_W-1:0] bus_s;
  logic cs_s, wstb_s, oe_s, low_s, hv_s;
  logic [AW-1:0] addr_s;
  logic [DW-1:0] data_s;

  // control pins: strobes reset inactive (high), flags reset low
  wsc_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(5'b11100)) u_ctl_sync (
    .clk(clk), .rst_n(rst_n),
    .d({cs_n, wstb_n, ren_n, supply_low, hv_enable}),
    .q(ctl_s)
  );

  // buses use the same depth so they stay aligned with the strobes
  wsc_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_bus_sync (
    .clk(clk), .rst_n(rst_n),
    .d({addr_in, data_in}),
    .q(bus_s)
  );

  assign {cs_s, wstb_s, oe_s, low_s, hv_s} = ctl_s;
  assign {addr_s, data_s} = bus_s;

  logic sel_s, sel_q;
  assign sel_s = !cs_s && !wstb_s;

  // power-up inhibit: arm only after the synchronizers filled and idle was seen
  logic [SYNC_STAGES-1:0] fill_q;
  logic armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q  <= '0;
      armed_q <= 1'b0;
      sel_q   <= 1'b0;
    end else begin
      fill_q <= {fill_q[SYNC_STAGES-2:0], 1'b1};
      sel_q  <= sel_s;
      if (fill_q[SYNC_STAGES-1] && !sel_s) armed_q <= 1'b1;
    end
  end

  wc_state_e state_q;
  logic start, in_cycle, stop, ok_q, len_met;
  logic [AW-1:0] cap_addr_q;

  assign in_cycle = (state_q == WC_ACTIVE);
  assign start    = (state_q == WC_IDLE) && armed_q && sel_s && !sel_q && oe_s && !low_s;
  assign stop     = in_cycle && !sel_s;

  wsc_low_timer #(.MIN_LOW(MIN_LOW)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .restart(start),
    .run(in_cycle && sel_s),
    .met(len_met)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= WC_IDLE;
      ok_q       <= 1'b0;
      cap_addr_q <= '0;
      cmd_valid  <= 1'b0;
      cmd_addr   <= '0;
      cmd_data   <= '0;
    end else begin
      cmd_valid <= 1'b0;
      if (start) begin
        state_q    <= WC_ACTIVE;
        ok_q       <= 1'b1;
        cap_addr_q <= addr_s;
      end else if (in_cycle) begin
        if (!oe_s || low_s) ok_q <= 1'b0;
        if (stop) begin
          state_q <= WC_IDLE;
          if (ok_q && oe_s && !low_s && hv_s && len_met) begin
            cmd_valid <= 1'b1;
            cmd_addr  <= cap_addr_q;
            cmd_data  <= data_s;
          end
        end
      end
    end
  end

  assign read_reset_req = low_s;
endmodule

// File: rtl/wsc_checker.sv
module wsc_checker (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic read_reset_req,
  input logic hv_s,
  input logic oe_s
);
  AST_ONE_CLK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid); // R9

  AST_LOCKOUT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    read_reset_req |=> !cmd_valid); // R6

  AST_HV_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    !hv_s |=> !cmd_valid); // R7

  AST_OE_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_s |=> !cmd_valid); // R5
endmodule

bind strobe_write_capture wsc_checker u_wsc_checker (
  .clk(clk),
  .rst_n(rst_n),
  .cmd_valid(cmd_valid),
  .read_reset_req(read_reset_req),
  .hv_s(hv_s),
  .oe_s(oe_s)
);

// File: tb/strobe_write_capture_bench.sv
`timescale 1ns/1ps
module strobe_write_capture_bench;
  localparam int AW = 15;
  localparam int DW = 8;
  localparam int MIN_LOW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, wstb_n = 1'b1, ren_n = 1'b1;
  logic [AW-1:0] addr_in = '0;
  logic [DW-1:0] data_in = '0;
  logic supply_low = 1'b0, hv_enable = 1'b1;
  logic cmd_valid, read_reset_req;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_data;

  int checks = 0, fails = 0, pulses = 0;
  logic [AW-1:0] got_addr;
  logic [DW-1:0] got_data;
  bit done = 0;

  always #2 clk = ~clk;

  strobe_write_capture #(.AW(AW), .DW(DW), .MIN_LOW(MIN_LOW)) u_strobe_write_capture (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wstb_n(wstb_n), .ren_n(ren_n),
    .addr_in(addr_in), .data_in(data_in), .supply_low(supply_low),
    .hv_enable(hv_enable), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .read_reset_req(read_reset_req)
  );

  always @(negedge clk) begin
    if (cmd_valid) begin
      pulses   <= pulses + 1;
      got_addr <= cmd_addr;
      got_data <= cmd_data;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // drives one strobe cycle; both-low overlap lasts low_len clock samples
  task automatic run_cycle(input bit cs_first, input int fall_gap, input int low_len,
                           input bit cs_rise_first, input int rise_gap,
                           input logic [AW-1:0] a0, input logic [AW-1:0] a1,
                           input logic [DW-1:0] d0, input logic [DW-1:0] d1);
    @(negedge clk);
    pulses  = 0;
    addr_in = a0;
    data_in = d0;
    if (cs_first) cs_n = 1'b0; else wstb_n = 1'b0;
    if (fall_gap > 0) idle(fall_gap);
    cs_n = 1'b0; wstb_n = 1'b0; addr_in = a1;
    if (low_len == 1) data_in = d1;
    for (int i = 1; i < low_len; i++) begin
      @(negedge clk);
      addr_in = ~a1;
      if (i == low_len - 1) data_in = d1;
    end
    @(negedge clk);
    if (cs_rise_first) cs_n = 1'b1; else wstb_n = 1'b1;
    if (rise_gap > 0) idle(rise_gap);
    cs_n = 1'b1; wstb_n = 1'b1;
    @(negedge clk);
    data_in = ~d1;
    addr_in = ~a0;
    idle(8);
  endtask

  task automatic simple_write(input int low_len, input logic [AW-1:0] a,
                              input logic [DW-1:0] d);
    run_cycle(1'b1, 0, low_len, 1'b1, 0, a, a, d, d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(6);
    // R9 reset state
    chk(cmd_valid == 1'b0, "R9", "reset cmd_valid", cmd_valid, 0);
    chk(read_reset_req == 1'b0, "R9", "reset read_reset_req", read_reset_req, 0);

    // R2 R3 R4 R9 sweep over orderings and overlap lengths
    for (int cf = 0; cf < 2; cf++)
      for (int fg = 0; fg < 3; fg += 2)
        for (int cr = 0; cr < 2; cr++)
          for (int rg = 0; rg < 2; rg++)
            for (int len = 1; len <= 5; len++) begin
              automatic int k = ((cf*2 + fg/2)*2 + cr)*10 + rg*5 + len;
              automatic logic [AW-1:0] a0 = AW'(k * 97 + 5);
              automatic logic [AW-1:0] a1 = AW'(k * 389 + 1234);
              automatic logic [DW-1:0] d0 = DW'(k * 13 + 7);
              automatic logic [DW-1:0] d1 = DW'(k * 29 + 100);
              automatic int exp_p = (len >= MIN_LOW) ? 1 : 0;
              run_cycle(cf[0], fg, len, cr[0], rg, a0, a1, d0, d1);
              chk(pulses == exp_p, "R4_R9", $sformatf("pulse count k=%0d len=%0d", k, len),
                  pulses, exp_p);
              if (exp_p == 1 && pulses == 1) begin
                chk(got_addr == a1, "R2", $sformatf("addr k=%0d", k), got_addr, a1);
                chk(got_data == d1, "R3", $sformatf("data k=%0d", k), got_data, d1);
              end
            end

    // R1 single strobe low
    @(negedge clk); pulses = 0; cs_n = 1'b0; idle(6); cs_n = 1'b1; idle(8);
    chk(pulses == 0, "R1", "cs alone", pulses, 0);
    @(negedge clk); pulses = 0; wstb_n = 1'b0; idle(6); wstb_n = 1'b1; idle(8);
    chk(pulses == 0, "R1", "wstb alone", pulses, 0);
    // R1 both low while read enable low, read enable rises later
    @(negedge clk); pulses = 0; ren_n = 1'b0; cs_n = 1'b0; wstb_n = 1'b0; idle(4);
    ren_n = 1'b1; idle(4); cs_n = 1'b1; wstb_n = 1'b1; idle(8);
    chk(pulses == 0, "R1", "read enable low at start", pulses, 0);

    // R5 read enable drops mid-cycle
    @(negedge clk); pulses = 0; cs_n = 1'b0; wstb_n = 1'b0; idle(4);
    ren_n = 1'b0; idle(1); ren_n = 1'b1; idle(3); cs_n = 1'b1; wstb_n = 1'b1; idle(8);
    chk(pulses == 0, "R5", "read enable mid-cycle", pulses, 0);
    // R5 read enable drops together with release
    @(negedge clk); pulses = 0; cs_n = 1'b0; wstb_n = 1'b0; idle(4);
    cs_n = 1'b1; wstb_n = 1'b1; ren_n = 1'b0; idle(2); ren_n = 1'b1; idle(8);
    chk(pulses == 0, "R5", "read enable at release", pulses, 0);

    // R6 supply lockout
    @(negedge clk); supply_low = 1'b1; idle(4);
    chk(read_reset_req == 1'b1, "R6", "read_reset_req high", read_reset_req, 1);
    simple_write(5, AW'(321), DW'(8'h5A));
    chk(pulses == 0, "R6", "write during lockout", pulses, 0);
    // R6 lockout arriving mid-cycle
    supply_low = 1'b0; idle(4);
    chk(read_reset_req == 1'b0, "R6", "read_reset_req cleared", read_reset_req, 0);
    @(negedge clk); pulses = 0; cs_n = 1'b0; wstb_n = 1'b0; idle(3);
    supply_low = 1'b1; idle(1); supply_low = 1'b0; idle(3);
    cs_n = 1'b1; wstb_n = 1'b1; idle(8);
    chk(pulses == 0, "R6", "lockout mid-cycle", pulses, 0);
    simple_write(4, AW'(777), DW'(8'hC3));
    chk(pulses == 1 && got_data == 8'hC3, "R6", "write after lockout", pulses, 1);

    // R7 high-voltage enable
    hv_enable = 1'b0;
    simple_write(5, AW'(55), DW'(8'h11));
    chk(pulses == 0, "R7", "write without hv", pulses, 0);
    hv_enable = 1'b1;
    simple_write(5, AW'(56), DW'(8'h22));
    chk(pulses == 1 && got_addr == AW'(56), "R7", "write with hv addr", got_addr, 56);

    // R8 power-up with strobes active
    @(negedge clk); rst_n = 1'b0; cs_n = 1'b0; wstb_n = 1'b0; ren_n = 1'b1; idle(4);
    rst_n = 1'b1; pulses = 0; idle(6);
    wstb_n = 1'b1; cs_n = 1'b1; idle(8);
    chk(pulses == 0, "R8", "active at reset release", pulses, 0);
    simple_write(3, AW'(4095), DW'(8'hE7));
    chk(pulses == 1, "R8", "write after arming", pulses, 1);
    chk(got_data == 8'hE7, "R8", "data after arming", got_data, 8'hE7);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule